// File: doc/BRIEF.md
# Multi-Stream SDI Receive Line Decoder

This block sits behind a stream deinterleaver in a high-rate serial digital video receiver. It takes up to sixteen parallel 10-bit elementary streams that share one data-valid enable. Each lane looks for timing reference sequences and reports whether each one marks the start or the end of active video. Behind every end marker it picks up the two line-number words and the two check words. Each lane keeps its own line number and its own line CRC verdict, so a fault on one elementary stream shows up on that stream's outputs alone.

A mode input selects eight or sixteen active lanes. With eight lanes the enable is normally high on every second clock. With sixteen lanes it is high on one clock in four, with the core clock at 297 MHz or 297/1.001 MHz. The lanes advance only on enabled clocks, so any duty pattern is handled the same way. Serial reception, clock recovery, deinterleaving and ancillary payload extraction sit outside this block.

Top module: `sdi_ml_rx_dec`

## Requirements
- R1: While `rst_n` is low, every output is zero: `trs_o`, `eav_o`, all `ln_o` lanes and all `crc_err_o` bits.
- R2: A lane detects a reference sequence when the word it consumes follows the words 0x3FF, 0x000, 0x000 on its three previous enabled clocks. `trs_o` is the OR of the detections of all active lanes for the most recently consumed word. It is visible from the enabled clock edge that consumed the fourth word until the next enabled edge.
- R3: `eav_o` follows the same timing as `trs_o`, for sequences whose fourth word has bit 6 set (end marker). A fourth word with bit 6 clear is a start marker: it raises `trs_o` but not `eav_o`.
- R4: The two words after an end marker carry the 11-bit line number. Bits [6:0] of the number are in bits [8:2] of the first word, and bits [10:7] are in bits [5:2] of the second word. The lane's `ln_o` takes the new value from the enabled edge that consumes the second word.
- R5: Each lane runs an 18-bit CRC with polynomial x^18+x^5+x^4+1. The CRC processes each 10-bit word LSB first. For each bit, fb = bit XOR crc[0], the register shifts right, fb enters bit 17, and fb is XORed into bits 13 and 12. The two words after the line-number words carry crc[8:0] and crc[17:9] in their bits [8:0]. `crc_err_o` for the lane updates on the edge that consumes the second check word: 1 on any mismatch, 0 on a match.
- R6: The CRC is cleared to zero on a start marker. It covers the words from the one after the start marker through the second line-number word. Words outside that span do not affect it. If no start marker was consumed before an end marker, that line's check words are not compared and `crc_err_o` keeps its value.
- R7: Lane state and all outputs change only on clocks with `ce_i` high. Data present on other clocks is ignored, so both the 50% and the 25% enable patterns decode correctly.
- R8: With `mode16_i` low, lanes 8 to 15 are held cleared and their `ln_o` and `crc_err_o` read zero whatever their inputs carry. With `mode16_i` high, all sixteen lanes decode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Data-valid enable shared by all lanes |
| mode16_i | input | 1 | 1: sixteen active lanes, 0: eight active lanes |
| ds_i | input | NUM_STREAMS x 10 | Elementary stream words, lane 0 in the lowest slice |
| trs_o | output | 1 | Reference sequence seen on the last consumed word |
| eav_o | output | 1 | End-of-active-video marker seen on the last consumed word |
| ln_o | output | NUM_STREAMS x 11 | Captured line number per lane |
| crc_err_o | output | NUM_STREAMS | Line CRC mismatch flag per lane |

## Verification
Corrupted per-lane state reaches the ports within one line.
- A history register that drifts loses or invents reference sequences. This shows on `trs_o` and `eav_o` at the very next marker.
- A phase counter that is off by one word latches the wrong line-number bits one line later.
- A CRC register that picks up words outside its span flips `crc_err_o` on the check words of the same line.

The bench runs a behavioural model every clock, so any such divergence is caught on the cycle it appears. Garbage placed on clocks without the enable exposes a lane that consumes data it should skip.

// File: rtl/sdi_ml_pkg.sv
package sdi_ml_pkg;

    localparam int DW        = 10;          // elementary stream word width
    localparam int LNW       = 11;          // line number width
    localparam int CRCW      = 18;          // line CRC width
    localparam int LN_LO_W   = 7;           // line bits carried in first LN word
    localparam int LN_HI_W   = LNW - LN_LO_W;
    localparam int CR_HALF   = CRCW / 2;    // CRC bits per check word
    localparam int MARK_BIT  = 6;           // end/start discriminator in fourth word

    localparam logic [DW-1:0] WORD_ONES = '1;
    localparam logic [DW-1:0] WORD_ZERO = '0;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_LN0,
        PH_LN1,
        PH_CR0,
        PH_CR1
    } phase_e;

    typedef struct packed {
        logic [DW-1:0]      h1;      // newest consumed word
        logic [DW-1:0]      h2;
        logic [DW-1:0]      h3;      // oldest consumed word
        phase_e             ph;
        logic [CRCW-1:0]    crc;
        logic               run;     // CRC accumulating
        logic               chk;     // compare check words of this line
        logic [LN_LO_W-1:0] ln_lo;
        logic [CR_HALF-1:0] cr0;
        logic [LNW-1:0]     ln;
        logic               err;
        logic               trs;
        logic               eav;
    } lane_st_t;

endpackage

// File: rtl/sdi_ml_crc18.sv
module sdi_ml_crc18
    import sdi_ml_pkg::*;
(
    input  logic [CRCW-1:0] crc_i,
    input  logic [DW-1:0]   word_i,
    output logic [CRCW-1:0] crc_o
);

    // Reflected taps for the x^4 and x^5 terms in a right-shifting register.
    localparam int TAP_X4 = CRCW - 1 - 4;
    localparam int TAP_X5 = CRCW - 1 - 5;

    always_comb begin
        logic [CRCW-1:0] acc;
        logic            fb;
        acc = crc_i;
        for (int b = 0; b < DW; b++) begin
            fb  = acc[0] ^ word_i[b];
            acc = {fb, acc[CRCW-1:1]};
            acc[TAP_X4] = acc[TAP_X4] ^ fb;
            acc[TAP_X5] = acc[TAP_X5] ^ fb;
        end
        crc_o = acc;
    end

endmodule

// File: rtl/sdi_ml_stream.sv
module sdi_ml_stream
    import sdi_ml_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           clr_i,
    input  logic [DW-1:0]  word_i,
    output logic           trs_o,
    output logic           eav_o,
    output logic [LNW-1:0] ln_o,
    output logic           err_o
);

    lane_st_t        st_q;
    lane_st_t        st_d;
    logic [CRCW-1:0] crc_step;
    logic            seq_hit;
    logic            is_end;
    logic            is_start;

    sdi_ml_crc18 u_crc (
        .crc_i  (st_q.crc),
        .word_i (word_i),
        .crc_o  (crc_step)
    );

    assign seq_hit  = (st_q.h3 == WORD_ONES) && (st_q.h2 == WORD_ZERO) &&
                      (st_q.h1 == WORD_ZERO);
    assign is_end   = seq_hit &&  word_i[MARK_BIT];
    assign is_start = seq_hit && !word_i[MARK_BIT];

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (en_i) begin
            st_d.h3  = st_q.h2;
            st_d.h2  = st_q.h1;
            st_d.h1  = word_i;
            st_d.trs = seq_hit;
            st_d.eav = is_end;
            if (st_q.run) begin
                st_d.crc = crc_step;
            end
            case (st_q.ph)
                PH_WAIT: begin
                    if (is_end) begin
                        st_d.ph  = PH_LN0;
                        st_d.chk = st_q.run;
                    end
                end
                PH_LN0: begin
                    st_d.ln_lo = word_i[LN_LO_W+1:2];
                    st_d.ph    = PH_LN1;
                end
                PH_LN1: begin
                    st_d.ln  = {word_i[LN_HI_W+1:2], st_q.ln_lo};
                    st_d.run = 1'b0;
                    st_d.ph  = PH_CR0;
                end
                PH_CR0: begin
                    st_d.cr0 = word_i[CR_HALF-1:0];
                    st_d.ph  = PH_CR1;
                end
                PH_CR1: begin
                    if (st_q.chk) begin
                        st_d.err = (st_q.crc[CR_HALF-1:0] != st_q.cr0) ||
                                   (st_q.crc[CRCW-1:CR_HALF] != word_i[CR_HALF-1:0]);
                    end
                    st_d.chk = 1'b0;
                    st_d.ph  = PH_WAIT;
                end
                default: st_d.ph = PH_WAIT;
            endcase
            if (is_start) begin
                st_d.crc = '0;
                st_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trs_o = st_q.trs;
    assign eav_o = st_q.eav;
    assign ln_o  = st_q.ln;
    assign err_o = st_q.err;

endmodule

// File: rtl/sdi_ml_rx_dec.sv
module sdi_ml_rx_dec
    import sdi_ml_pkg::*;
#(
    parameter int NUM_STREAMS  = 16,
    parameter int BASE_STREAMS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ce_i,
    input  logic                              mode16_i,
    input  logic [NUM_STREAMS-1:0][DW-1:0]    ds_i,
    output logic                              trs_o,
    output logic                              eav_o,
    output logic [NUM_STREAMS-1:0][LNW-1:0]   ln_o,
    output logic [NUM_STREAMS-1:0]            crc_err_o
);

    logic [NUM_STREAMS-1:0] lane_on;
    logic [NUM_STREAMS-1:0] lane_trs;
    logic [NUM_STREAMS-1:0] lane_eav;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_lane
        if (g < BASE_STREAMS) begin : g_base
            assign lane_on[g] = 1'b1;
        end else begin : g_ext
            assign lane_on[g] = mode16_i;
        end

        sdi_ml_stream u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (ce_i & lane_on[g]),
            .clr_i  (~lane_on[g]),
            .word_i (ds_i[g]),
            .trs_o  (lane_trs[g]),
            .eav_o  (lane_eav[g]),
            .ln_o   (ln_o[g]),
            .err_o  (crc_err_o[g])
        );
    end

    // Inactive lanes are held cleared, so a plain OR covers only active lanes.
    assign trs_o = |lane_trs;
    assign eav_o = |lane_eav;

endmodule

// File: rtl/sdi_ml_rx_dec_chk.sv
module sdi_ml_rx_dec_chk #(
    parameter int NS   = 16,
    parameter int BASE = 8,
    parameter int LNW  = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ce_i,
    input logic                    mode16_i,
    input logic                    trs_o,
    input logic                    eav_o,
    input logic [NS-1:0][LNW-1:0]  ln_o,
    input logic [NS-1:0]           crc_err_o
);

    // R3: an end marker is always also a reference sequence
    p_eav_in_trs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eav_o |-> trs_o);

    // R2 with R7: strobe holds across clocks without enable
    p_trs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i && mode16_i) |=> $stable(trs_o));

    // R4 with R7: line numbers hold across clocks without enable
    p_ln_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i && mode16_i) |=> $stable(ln_o));

    // R5 with R7: CRC flags hold across clocks without enable
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i && mode16_i) |=> $stable(crc_err_o));

    if (NS > BASE) begin : g_ext_chk
        // R8: upper lanes read zero in eight-lane mode
        p_upper_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !mode16_i |=> (ln_o[NS-1:BASE] == '0) && (crc_err_o[NS-1:BASE] == '0));
    end

endmodule

bind sdi_ml_rx_dec sdi_ml_rx_dec_chk #(
    .NS   (NUM_STREAMS),
    .BASE (BASE_STREAMS),
    .LNW  (sdi_ml_pkg::LNW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_i),
    .mode16_i  (mode16_i),
    .trs_o     (trs_o),
    .eav_o     (eav_o),
    .ln_o      (ln_o),
    .crc_err_o (crc_err_o)
);

// File: tb/tb_sdi_ml_rx_dec.sv
module tb_sdi_ml_rx_dec;

    localparam int NS   = 16;
    localparam int BASE = 8;
    localparam int NACT = 20;
    localparam int NHAN = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ce = 1'b0;
    logic                 mode16 = 1'b0;
    logic [NS-1:0][9:0]   ds = '0;
    logic                 trs_o;
    logic                 eav_o;
    logic [NS-1:0][10:0]  ln_o;
    logic [NS-1:0]        err_o;

    int total = 0;
    int bad   = 0;

    sdi_ml_rx_dec #(.NUM_STREAMS(NS), .BASE_STREAMS(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .mode16_i(mode16), .ds_i(ds),
        .trs_o(trs_o), .eav_o(eav_o), .ln_o(ln_o), .crc_err_o(err_o)
    );

    always #2.5ns clk = ~clk;

    // ---------------- behavioural reference ----------------
    int m_h0[NS], m_h1[NS], m_h2[NS];
    int m_cnt[NS], m_crc[NS], m_ln[NS], m_lnlo[NS], m_cr0[NS];
    bit m_run[NS], m_chk[NS], m_err[NS], m_trs[NS], m_eav[NS];

    function automatic int crc_word(int c, logic [9:0] w);
        int r = c;
        for (int b = 0; b < 10; b++) begin
            int fb = (r ^ int'(w[b])) & 1;
            r = r >> 1;
            if (fb != 0) r = r ^ 'h23000;
        end
        return r;
    endfunction

    task automatic model_clear(int i);
        m_h0[i] = 0; m_h1[i] = 0; m_h2[i] = 0; m_cnt[i] = 0; m_crc[i] = 0;
        m_ln[i] = 0; m_lnlo[i] = 0; m_cr0[i] = 0; m_run[i] = 0; m_chk[i] = 0;
        m_err[i] = 0; m_trs[i] = 0; m_eav[i] = 0;
    endtask

    task automatic model_step(int i, logic [9:0] w);
        bit t = (m_h0[i] == 1023) && (m_h1[i] == 0) && (m_h2[i] == 0);
        int nc = m_run[i] ? crc_word(m_crc[i], w) : m_crc[i];
        case (m_cnt[i])
            0: if (t && w[6]) begin m_cnt[i] = 1; m_chk[i] = m_run[i]; end
            1: begin m_lnlo[i] = int'(w[8:2]); m_cnt[i] = 2; end
            2: begin m_ln[i] = (int'(w[5:2]) << 7) | m_lnlo[i]; m_run[i] = 0; m_cnt[i] = 3; end
            3: begin m_cr0[i] = int'(w[8:0]); m_cnt[i] = 4; end
            default: begin
                if (m_chk[i])
                    m_err[i] = ((m_crc[i] & 511) != m_cr0[i]) || ((m_crc[i] >> 9) != int'(w[8:0]));
                m_chk[i] = 0; m_cnt[i] = 0;
            end
        endcase
        if (t && !w[6]) begin nc = 0; m_run[i] = 1; end
        m_crc[i] = nc;
        m_h0[i] = m_h1[i]; m_h1[i] = m_h2[i]; m_h2[i] = int'(w);
        m_trs[i] = t; m_eav[i] = t && w[6];
    endtask

    always @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < NS; i++) begin
            if (!rst_n || (i >= BASE && !mode16)) model_clear(i);
            else if (ce) model_step(i, ds[i]);
        end
    end

    // ---------------- checking ----------------
    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit et = 0, ee = 0;
        for (int i = 0; i < NS; i++) begin et |= m_trs[i]; ee |= m_eav[i]; end
        check(trs_o == et, "R2 trs strobe", int'(trs_o), int'(et));
        check(eav_o == ee, "R3 eav strobe", int'(eav_o), int'(ee));
        for (int i = 0; i < NS; i++) begin
            check(int'(ln_o[i]) == m_ln[i], (i >= BASE) ? "R8 upper lane line" : "R4 lane line",
                  int'(ln_o[i]), m_ln[i]);
            check(err_o[i] == m_err[i], (i >= BASE) ? "R8 upper lane crc" : "R5 lane crc",
                  int'(err_o[i]), int'(m_err[i]));
        end
    endtask

    // ---------------- stimulus ----------------
    logic [9:0] lw [NS][64];
    int llen;

    function automatic int ln_of(int line, int i);
        return (line * 97 + i * 61 + 1000) % 2048;
    endfunction

    task automatic build_line(int line, bit with_sav, int bad_lane);
        for (int i = 0; i < NS; i++) begin
            int k = 0, c = 0, n;
            logic [10:0] lnv;
            logic [17:0] cv;
            if (with_sav) begin
                lw[i][0] = 10'h3FF; lw[i][1] = 10'h000; lw[i][2] = 10'h000; lw[i][3] = 10'h200;
                k = 4;
            end
            for (int j = 0; j < NACT; j++) begin
                lw[i][k] = 10'(10'h040 + (i * 37 + j * 13 + line * 7) % 896);
                c = crc_word(c, lw[i][k]); k++;
            end
            lw[i][k] = 10'h3FF; c = crc_word(c, lw[i][k]); k++;
            lw[i][k] = 10'h000; c = crc_word(c, lw[i][k]); k++;
            lw[i][k] = 10'h000; c = crc_word(c, lw[i][k]); k++;
            lw[i][k] = 10'h2D8; c = crc_word(c, lw[i][k]); k++;
            n = ln_of(line, i);
            lnv = 11'(n);
            lw[i][k] = {~lnv[6], lnv[6:0], 2'b00}; c = crc_word(c, lw[i][k]); k++;
            lw[i][k] = {4'b1000, lnv[10:7], 2'b00}; c = crc_word(c, lw[i][k]); k++;
            if (!with_sav || i == bad_lane) c = c ^ 1;
            cv = 18'(c);
            lw[i][k] = {~cv[8], cv[8:0]};   k++;
            lw[i][k] = {~cv[17], cv[17:9]}; k++;
            for (int j = 0; j < NHAN; j++) begin
                lw[i][k] = 10'(10'h100 + j + line); k++;
            end
            llen = k;
        end
    endtask

    task automatic send_line();
        for (int k = 0; k < llen; k++) begin
            @(negedge clk); compare_all();
            ce = 1'b1;
            for (int i = 0; i < NS; i++) ds[i] = lw[i][k];
            for (int g = 0; g < (mode16 ? 3 : 1); g++) begin
                @(negedge clk); compare_all();
                ce = 1'b0;
                ds = (g == 0) ? '1 : '0;   // R7: junk on clocks without enable
            end
        end
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk); compare_all();
            ce = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        check(trs_o == 0 && eav_o == 0, "R1 strobes in reset", int'({trs_o, eav_o}), 0);
        check(ln_o == '0, "R1 line numbers in reset", int'(ln_o[0]), 0);
        check(err_o == '0, "R1 crc flags in reset", int'(err_o), 0);
        rst_n = 1'b1;
        idle(2);

        // eight-lane mode, 50% enable; first line has no start marker
        build_line(0, 1'b0, -1);
        send_line();
        check(err_o == '0, "R6 no compare without start marker", int'(err_o), 0);
        check(int'(ln_o[7]) == ln_of(0, 7), "R4 lane 7 line", int'(ln_o[7]), ln_of(0, 7));
        check(ln_o[8] == '0, "R8 lane 8 idle in eight-lane mode", int'(ln_o[8]), 0);

        build_line(1, 1'b1, 3);
        send_line();
        check(err_o[3] == 1'b1, "R5 corrupted lane 3 flagged", int'(err_o[3]), 1);
        check(err_o[2] == 1'b0, "R5 clean lane 2 not flagged", int'(err_o[2]), 0);

        build_line(2, 1'b1, -1);
        send_line();
        check(err_o[3] == 1'b0, "R5 lane 3 clears on good line", int'(err_o[3]), 0);
        check(int'(ln_o[5]) == ln_of(2, 5), "R4 lane 5 line", int'(ln_o[5]), ln_of(2, 5));
        check(err_o[NS-1:BASE] == '0, "R8 upper crc idle", int'(err_o[NS-1:BASE]), 0);

        // sixteen-lane mode, 25% enable
        @(negedge clk); compare_all(); mode16 = 1'b1; ce = 1'b0;
        build_line(3, 1'b1, 12);
        send_line();
        check(err_o[12] == 1'b1, "R8 lane 12 active and flagged", int'(err_o[12]), 1);
        check(err_o[11] == 1'b0, "R5 lane 11 clean", int'(err_o[11]), 0);
        check(int'(ln_o[15]) == ln_of(3, 15), "R8 lane 15 line", int'(ln_o[15]), ln_of(3, 15));

        build_line(4, 1'b1, -1);
        send_line();
        check(err_o == '0, "R5 all lanes clean", int'(err_o), 0);
        check(int'(ln_o[0]) == ln_of(4, 0), "R7 lane 0 line at 25% enable", int'(ln_o[0]), ln_of(4, 0));

        // back to eight lanes: upper lanes clear
        @(negedge clk); compare_all(); mode16 = 1'b0;
        idle(2);
        check(ln_o[NS-1:BASE] == '0, "R8 upper lanes cleared", int'(ln_o[15]), 0);
        check(int'(ln_o[1]) == ln_of(4, 1), "R8 base lane kept", int'(ln_o[1]), ln_of(4, 1));

        build_line(5, 1'b1, 0);
        send_line();
        check(err_o[0] == 1'b1, "R5 lane 0 flagged", int'(err_o[0]), 1);
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule